// File: doc/BRIEF.md
# Serial Setup Register Port

This block takes a 32-bit configuration word from a host over four slow, asynchronous lines: a serial data line, a host clock and two mode lines. Every line is brought into the system clock domain first. The block then tracks the rising and falling edges of the host clock.

On each rising edge of the host clock, the block samples the two mode lines and decodes them into one of four modes:

- run
- data transfer
- latch the setup word
- latch a waveform byte

In data-transfer mode, each falling edge of the host clock moves one data bit into a staging register. When the host clock rises with the setup-latch code present, the staged word is copied into a holding register. That holding register drives the generator's configuration fields: the offset code, the playback-counter reset, the trigger source, the sample-rate select, the attenuator select, the 15-bit playback start address and the filter enable.

The block also produces two signals for the neighbouring waveform byte register, which sits on the same data line:

- a shift pulse for every transferred bit
- a latch strobe

The block passes every field through unchanged. Voltage scaling and counter control belong to the logic downstream.

Top module: `serial_setup_port`

## Requirements
- R1: The mode lines, read as {host_c1, host_c0}, decode as follows, and exactly one of the four mode outputs is high at any time:
  - 00 selects run (`mode_run`)
  - 11 selects data transfer (`mode_xfer`)
  - 10 selects setup latch (`load_setup`)
  - 01 selects wave latch (`load_wave`)
- R2: The mode outputs take a new value only after a rising edge of the host clock. A change on the mode lines without such an edge leaves them unchanged.
- R3: While the decoded mode is data transfer, each falling edge of the host clock shifts exactly one bit into the staging register and raises `shift_pulse` for exactly one system clock cycle.
- R4: Bits enter MSB first, so that after 32 shifts:
  - the first bit sent lands in `filter_en`
  - the next fifteen bits land in `start_addr[14]` down to `start_addr[0]`
  - the last bit sent lands in `offset_code[0]`
- R5: A rising edge of the host clock with the setup-latch code on the mode lines copies the whole staged word into the holding outputs and raises `load_setup`. At all other times the holding outputs keep their value.
- R6: Holding word layout, from bit 0 upward:
  - bits 7:0 are `offset_code`
  - bit 8 is `play_rst_n`
  - bit 9 is `trig_sel`
  - bits 12:10 are `rate_sel`
  - bits 15:13 are `atten_sel`
  - bits 30:16 are `start_addr`
  - bit 31 is `filter_en`

  The offset code passes through unchanged: 0x00 stands for the negative extreme, 0x7F for zero and 0xFF for the positive extreme.
- R7: In run mode and setup-latch mode, falling edges of the host clock neither shift the staging register nor raise `shift_pulse`. A later setup latch therefore delivers the previously staged word.
- R8: A rising edge with the wave-latch code raises `load_wave` and leaves the holding outputs unchanged.
- R9: While `rst_n` is low at a system clock edge, the staging and holding registers clear to zero and the decoded mode returns to run. As a result, `play_rst_n` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_clk | input | 1 | Host serial clock, asynchronous |
| host_data | input | 1 | Host serial data, asynchronous |
| host_c0 | input | 1 | Mode line 0, asynchronous |
| host_c1 | input | 1 | Mode line 1, asynchronous |
| offset_code | output | 8 | Output offset code |
| play_rst_n | output | 1 | Active-low reset for the playback address counters |
| trig_sel | output | 1 | Trigger source: 0 = sequence start, 1 = shaped output |
| rate_sel | output | 3 | Sample-rate and filter select code |
| atten_sel | output | 3 | Output attenuator select code |
| start_addr | output | 15 | Playback start address |
| filter_en | output | 1 | Output filter enable |
| mode_run | output | 1 | Decoded run mode |
| mode_xfer | output | 1 | Decoded data-transfer mode |
| load_setup | output | 1 | Setup latch strobe |
| load_wave | output | 1 | Waveform byte latch strobe |
| shift_pulse | output | 1 | One-cycle pulse per bit shifted in transfer mode |

## Verification
The following properties are checked on every cycle:

- the decoded mode moves only on a detected rising edge of the host clock
- the staging register is frozen unless a transfer-mode falling edge occurs
- a latch copies exactly the previously staged word, and the holding word is otherwise stable
- `shift_pulse` never appears outside transfer mode

Only the bench's scenarios can show the rest:

- the bit order and field layout of a complete word
- that the count of shift pulses matches the bits sent
- that clocking in run or latch mode leaves the staged word intact
- the effect of a partial word
- that a reset clears the staged word as well as the visible one

// File: rtl/setup_port_pkg.sv
package setup_port_pkg;

   // decoded operating mode, encoded as {c1, c0}
   typedef enum logic [1:0] {
      MODE_RUN   = 2'b00,
      MODE_WAVE  = 2'b01,
      MODE_SETUP = 2'b10,
      MODE_XFER  = 2'b11
   } port_mode_e;

   // bit positions inside the synchronized line bundle
   localparam int LN_CLK  = 0;
   localparam int LN_DATA = 1;
   localparam int LN_C0   = 2;
   localparam int LN_C1   = 3;
   localparam int LN_W    = 4;

endpackage

// File: rtl/host_line_sync.sv
module host_line_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 4,
   parameter int CLK_IX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] lines_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic [WIDTH-1:0] sync_out;
   logic             clk_prev_q;

   generate
      if (STAGES == 1) begin : g_bad_stages
         $error("host_line_sync: STAGES must be 0 (bypass) or at least 2");
      end
      if (CLK_IX >= WIDTH) begin : g_bad_index
         $error("host_line_sync: CLK_IX outside the line bundle");
      end

      if (STAGES == 0) begin : g_bypass
         assign sync_out = raw_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) stage_q[i] <= '0;
                  else        stage_q[i] <= raw_i;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) stage_q[i] <= '0;
                  else        stage_q[i] <= stage_q[i-1];
               end
            end
         end
         assign sync_out = stage_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) clk_prev_q <= 1'b0;
      else        clk_prev_q <= sync_out[CLK_IX];
   end

   assign lines_o = sync_out;
   assign rise_o  =  sync_out[CLK_IX] & ~clk_prev_q;
   assign fall_o  = ~sync_out[CLK_IX] &  clk_prev_q;

endmodule

// File: rtl/port_mode_decoder.sv
module port_mode_decoder
   import setup_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise_i,
   input  logic       fall_i,
   input  logic [1:0] mode_i,     // {c1, c0} as sampled now
   output port_mode_e mode_q,
   output logic       copy_en_o,  // rise with setup-latch code
   output logic       shift_en_o, // fall while in transfer mode
   output logic       run_o,
   output logic       xfer_o,
   output logic       setup_o,
   output logic       wave_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)      mode_q <= MODE_RUN;
      else if (rise_i) mode_q <= port_mode_e'(mode_i);
   end

   assign copy_en_o  = rise_i && (port_mode_e'(mode_i) == MODE_SETUP);
   assign shift_en_o = fall_i && (mode_q == MODE_XFER);

   always_comb begin
      run_o   = 1'b0;
      xfer_o  = 1'b0;
      setup_o = 1'b0;
      wave_o  = 1'b0;
      unique case (mode_q)
         MODE_RUN:   run_o   = 1'b1;
         MODE_XFER:  xfer_o  = 1'b1;
         MODE_SETUP: setup_o = 1'b1;
         MODE_WAVE:  wave_o  = 1'b1;
         default:    run_o   = 1'b1;
      endcase
   end

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_i |=> $stable(mode_q));

   // R2
   mode_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |=> (mode_q == port_mode_e'($past(mode_i))));

endmodule

// File: rtl/setup_shifter.sv
module setup_shifter #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en_i,
   input  logic              bit_i,
   input  logic              copy_en_i,
   output logic [WORD_W-1:0] stage_q,
   output logic [WORD_W-1:0] hold_q
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("setup_shifter: WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)          stage_q <= '0;
      else if (shift_en_i) stage_q <= {stage_q[WORD_W-2:0], bit_i};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         hold_q <= '0;
      else if (copy_en_i) hold_q <= stage_q;
   end

   // R7
   stage_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en_i |=> $stable(stage_q));

   // R3
   bit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en_i |=> (stage_q[0] == $past(bit_i)));

   // R5
   hold_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      copy_en_i |=> (hold_q == $past(stage_q)));

   // R5
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !copy_en_i |=> $stable(hold_q));

endmodule

// File: rtl/serial_setup_port.sv
module serial_setup_port
   import setup_port_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OFFSET_W    = 8,
   parameter int SEL_W       = 3,
   parameter int ADDR_W      = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_clk,
   input  logic                host_data,
   input  logic                host_c0,
   input  logic                host_c1,
   output logic [OFFSET_W-1:0] offset_code,
   output logic                play_rst_n,
   output logic                trig_sel,
   output logic [SEL_W-1:0]    rate_sel,
   output logic [SEL_W-1:0]    atten_sel,
   output logic [ADDR_W-1:0]   start_addr,
   output logic                filter_en,
   output logic                mode_run,
   output logic                mode_xfer,
   output logic                load_setup,
   output logic                load_wave,
   output logic                shift_pulse
);

   // field placement, low end first
   localparam int RST_BIT  = OFFSET_W;
   localparam int TRG_BIT  = RST_BIT + 1;
   localparam int RATE_LSB = TRG_BIT + 1;
   localparam int ATT_LSB  = RATE_LSB + SEL_W;
   localparam int ADDR_LSB = ATT_LSB + SEL_W;
   localparam int EN_BIT   = ADDR_LSB + ADDR_W;
   localparam int WORD_W   = EN_BIT + 1;

   generate
      if (OFFSET_W < 1 || SEL_W < 1 || ADDR_W < 1) begin : g_bad_fields
         $error("serial_setup_port: every field needs at least one bit");
      end
   endgenerate

   logic [LN_W-1:0]   raw_lines;
   logic [LN_W-1:0]   lines;
   logic              h_rise;
   logic              h_fall;
   port_mode_e        mode_q;
   logic              copy_en;
   logic              shift_en;
   logic [WORD_W-1:0] stage_word;
   logic [WORD_W-1:0] hold_word;

   always_comb begin
      raw_lines          = '0;
      raw_lines[LN_CLK]  = host_clk;
      raw_lines[LN_DATA] = host_data;
      raw_lines[LN_C0]   = host_c0;
      raw_lines[LN_C1]   = host_c1;
   end

   host_line_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (LN_W),
      .CLK_IX (LN_CLK)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw_lines),
      .lines_o (lines),
      .rise_o  (h_rise),
      .fall_o  (h_fall)
   );

   port_mode_decoder u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (h_rise),
      .fall_i     (h_fall),
      .mode_i     ({lines[LN_C1], lines[LN_C0]}),
      .mode_q     (mode_q),
      .copy_en_o  (copy_en),
      .shift_en_o (shift_en),
      .run_o      (mode_run),
      .xfer_o     (mode_xfer),
      .setup_o    (load_setup),
      .wave_o     (load_wave)
   );

   setup_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en_i (shift_en),
      .bit_i      (lines[LN_DATA]),
      .copy_en_i  (copy_en),
      .stage_q    (stage_word),
      .hold_q     (hold_word)
   );

   assign shift_pulse = shift_en;
   assign offset_code = hold_word[OFFSET_W-1:0];
   assign play_rst_n  = hold_word[RST_BIT];
   assign trig_sel    = hold_word[TRG_BIT];
   assign rate_sel    = hold_word[RATE_LSB +: SEL_W];
   assign atten_sel   = hold_word[ATT_LSB +: SEL_W];
   assign start_addr  = hold_word[ADDR_LSB +: ADDR_W];
   assign filter_en   = hold_word[EN_BIT];

   // R7
   no_stray_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_run || load_setup || load_wave) |-> !shift_pulse);

   // R8
   wave_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_rise && mode_q == MODE_XFER && {lines[LN_C1], lines[LN_C0]} == 2'b01)
         |=> $stable(hold_word));

   // R1
   one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mode_run, mode_xfer, load_setup, load_wave}) == 1);

endmodule

// File: tb/tb_serial_setup_port.sv
module tb_serial_setup_port;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD       = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hclk = 1'b0, hdata = 1'b0, c0 = 1'b0, c1 = 1'b0;
   logic [7:0]  offset_code;
   logic        play_rst_n, trig_sel, filter_en;
   logic [2:0]  rate_sel, atten_sel;
   logic [14:0] start_addr;
   logic        mode_run, mode_xfer, load_setup, load_wave, shift_pulse;

   int checks = 0;
   int errors = 0;
   int pulses = 0;

   serial_setup_port dut (
      .clk(clk), .rst_n(rst_n), .host_clk(hclk), .host_data(hdata),
      .host_c0(c0), .host_c1(c1), .offset_code(offset_code),
      .play_rst_n(play_rst_n), .trig_sel(trig_sel), .rate_sel(rate_sel),
      .atten_sel(atten_sel), .start_addr(start_addr), .filter_en(filter_en),
      .mode_run(mode_run), .mode_xfer(mode_xfer), .load_setup(load_setup),
      .load_wave(load_wave), .shift_pulse(shift_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) if (shift_pulse) pulses++;

   // pack the outputs per the R6 layout
   function automatic logic [31:0] seen_word();
      return {filter_en, start_addr, atten_sel, rate_sel, trig_sel, play_rst_n, offset_code};
   endfunction

   function automatic logic [3:0] seen_mode();
      return {mode_run, mode_xfer, load_setup, load_wave};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic a0, input logic a1, input logic k, input logic d);
      c0 = a0; c1 = a1; hclk = k; hdata = d;
      repeat (HOLD) @(negedge clk);
   endtask

   // send the low n bits of w, MSB first, in transfer mode
   task automatic send_bits(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         drive(1, 1, 0, w[i]);
         drive(1, 1, 1, w[i]);
         drive(1, 1, 0, w[i]);
      end
   endtask

   task automatic latch_setup();
      drive(0, 1, 0, 0); drive(0, 1, 1, 0); drive(0, 1, 0, 0);
   endtask

   task automatic go_run();
      drive(0, 0, 0, 0); drive(0, 0, 1, 0); drive(0, 0, 0, 0);
   endtask

   task automatic load_word(input logic [31:0] w);
      send_bits(w, 32); latch_setup(); go_run();
   endtask

   initial begin
      repeat (CLK_PERIOD * 100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] a_word;
      logic [31:0] rnd;
      void'($urandom(32'd7321));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 hold cleared", seen_word(), 32'h0);
      check("R9 play_rst_n low", {31'b0, play_rst_n}, 32'h0);
      check("R1 run after reset", {28'b0, seen_mode()}, 32'b1000);

      // R2: mode lines change without a rising edge
      drive(1, 1, 0, 0);
      check("R2 no edge keeps run", {28'b0, seen_mode()}, 32'b1000);
      drive(0, 0, 0, 0);

      // R4: single-bit words locate first and last bit
      pulses = 0;
      send_bits(32'h8000_0000, 32);
      check("R3 shift pulse count", pulses, 32);
      check("R1 transfer decode", {28'b0, seen_mode()}, 32'b0100);
      drive(0, 1, 0, 0); drive(0, 1, 1, 0);
      check("R5 setup strobe", {28'b0, seen_mode()}, 32'b0010);
      check("R4 first bit to filter_en", {31'b0, filter_en}, 32'h1);
      check("R4 other fields zero", seen_word() & 32'h7FFF_FFFF, 32'h0);
      drive(0, 1, 0, 0); go_run();
      check("R1 run decode", {28'b0, seen_mode()}, 32'b1000);
      load_word(32'h0000_0001);
      check("R4 last bit to offset_code[0]", seen_word(), 32'h1);
      load_word(32'h4000_0000);
      check("R4 second bit to start_addr[14]", {17'b0, start_addr}, 32'h4000);

      // R6: offset extremes pass through
      load_word(32'h0000_00FF);
      check("R6 offset 0xFF", {24'b0, offset_code}, 32'hFF);
      load_word(32'h0000_007F);
      check("R6 offset 0x7F", {24'b0, offset_code}, 32'h7F);

      // R6: random words, field by field
      for (int k = 0; k < 8; k++) begin
         rnd = $urandom;
         load_word(rnd);
         check("R6 whole word", seen_word(), rnd);
         check("R6 rate_sel", {29'b0, rate_sel}, {29'b0, rnd[12:10]});
         check("R6 atten_sel", {29'b0, atten_sel}, {29'b0, rnd[15:13]});
         check("R6 start_addr", {17'b0, start_addr}, {17'b0, rnd[30:16]});
      end

      // R7: clocking in run mode leaves the staged word
      a_word = 32'hA5C3_3C5A;
      load_word(a_word);
      pulses = 0;
      for (int i = 0; i < 32; i++) begin
         drive(0, 0, 1, i[0]); drive(0, 0, 0, i[0]);
      end
      check("R7 no pulses in run", pulses, 0);
      latch_setup();
      check("R7 run clocks kept stage", seen_word(), a_word);
      for (int i = 0; i < 8; i++) begin
         drive(0, 1, 1, 1); drive(0, 1, 0, 1);
      end
      check("R7 no pulses in setup latch", pulses, 0);
      go_run(); latch_setup();
      check("R7 latch clocks kept stage", seen_word(), a_word);
      go_run();

      // R8: wave latch leaves holding
      send_bits(32'h0123_4567, 32);
      drive(1, 0, 0, 0); drive(1, 0, 1, 0);
      check("R8 wave strobe", {28'b0, seen_mode()}, 32'b0001);
      check("R8 hold unchanged", seen_word(), a_word);
      drive(1, 0, 0, 0); go_run();

      // R3: partial word shifts left by the bits sent
      send_bits(32'h0000_009C, 8);
      latch_setup(); go_run();
      check("R3 partial shift", seen_word(), {8'h23, 8'h45, 8'h67, 8'h9C});

      // R9: reset mid-operation clears stage as well
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 hold cleared mid-run", seen_word(), 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      latch_setup();
      check("R9 stage cleared", seen_word(), 32'h0);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule